// File: doc/BRIEF.md
# Processor Hot-Plug Presence Map and Event Notifier

This block keeps a presence map with one bit per processor ID and tells firmware when that map changes. The host reads the map one byte at a time through a window of `MAP_BYTES` consecutive I/O addresses. Byte `k` holds IDs `8k` to `8k+7`, and the ID's low three bits select the bit. The map is read-only to the host. A side-band request port carries a processor ID and a plug/unplug flag. Each request sets or clears the addressed bit and latches the processor-event bit in a small general-purpose-event (GPE) register block.

The GPE block has two status bytes and two enable bytes. The status bytes are write-1-to-clear. The enable bytes are read/write. The level-sensitive interrupt `sci_o` is high when either of two conditions holds:
- status byte 0 AND enable byte 0 has the processor-event bit or the PCI hot-plug bit set;
- the power-management side supplies a pending enabled event on `pm_evt_i`.

Host reads are registered. Data and a claim strobe appear one cycle after the read strobe.

Top module: `cpu_hotplug_gpe`

## Requirements
- R1: After reset, map bits for IDs 0 to BOOT_CPUS-1 (default 4) are 1 and all other map bits are 0. All GPE status and enable bytes are 0, and `sci_o` is low.
- R2: A read at MAP_BASE+k (default 0xAF00+k, k in 0..31) returns map byte k on `io_rdata_o`, with `io_ack_o` high, in the cycle after `io_rd_i`. Bit j of byte k is ID 8k+j.
- R3: A request with ID below 256 sets the ID's bit when `req_plug_i`=1 and clears it when `req_plug_i`=0. Other bits are unchanged.
- R4: Every request with ID below 256 sets GPE status byte 0 bit 2 (mask 0x04).
- R5: A request with ID 256 or higher changes no map bit and no status bit.
- R6: Host writes into the map window leave the map unchanged.
- R7: Status bytes sit at GPE_BASE+0/+1 (default 0xAFE0/0xAFE1) and are write-1-to-clear. Enable bytes sit at GPE_BASE+2/+3 and are read/write. All four read back at their addresses.
- R8: `sci_o` is high exactly when ((status0 AND enable0) AND 0x06) is nonzero or `pm_evt_i` is high. It follows register changes in the same cycle.
- R9: A pulse on `pci_evt_i` sets status byte 0 bit 1 (mask 0x02).
- R10: When a write-1-to-clear of status bit 2 and a valid request occur in the same cycle, bit 2 ends set.
- R11: A read outside the map window and the GPE block leaves `io_ack_o` low and `io_rdata_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 16 | Host I/O byte address |
| io_rd_i | input | 1 | Host read strobe |
| io_wr_i | input | 1 | Host write strobe |
| io_wdata_i | input | 8 | Host write data |
| io_rdata_o | output | 8 | Read data, one cycle after the read |
| io_ack_o | output | 1 | Read claimed, one cycle after the read |
| req_valid_i | input | 1 | Hot-plug request strobe |
| req_id_i | input | 9 | Processor ID of the request |
| req_plug_i | input | 1 | 1 = plug, 0 = unplug |
| pci_evt_i | input | 1 | PCI hot-plug event pulse |
| pm_evt_i | input | 1 | Pending enabled power-management event |
| sci_o | output | 1 | Level-sensitive system control interrupt |

## Verification
Map and status updates from a request, a PCI pulse or a host write are visible after one clock edge. The bench applies each stimulus just after a falling edge and compares against its model at the next falling edge. `sci_o` is combinational from the registers and `pm_evt_i`, so it is checked at that same falling edge, after the registers have updated. Read data and the claim strobe come one edge after the read strobe, so each read is driven in one half-period and sampled a full cycle later, with no other stimulus in between.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;
  localparam int PCI_HP_BIT = 1;
  localparam int CPU_HP_BIT = 2;
  localparam logic [7:0] SCI_SRC_MASK = 8'h06;

  typedef enum logic [1:0] {
    GPE_STS0 = 2'd0,
    GPE_STS1 = 2'd1,
    GPE_EN0  = 2'd2,
    GPE_EN1  = 2'd3
  } gpe_sel_e;
endpackage

// File: rtl/cpuhp_present_map.sv
module cpuhp_present_map #(
  parameter int MAP_BYTES = 32,
  parameter int BOOT_CPUS = 4,
  localparam int NCPU  = MAP_BYTES * 8,
  localparam int IDX_W = $clog2(NCPU),
  localparam int ID_W  = IDX_W + 1,
  localparam int OFF_W = $clog2(MAP_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic             req_plug_i,
  input  logic [OFF_W-1:0] rd_idx_i,
  output logic [7:0]       rd_byte_o,
  output logic             req_ok_o
);
  logic [NCPU-1:0] map_q;
  logic [IDX_W-1:0] bit_idx;

  assign req_ok_o = req_valid_i && !req_id_i[ID_W-1];
  assign bit_idx  = req_id_i[IDX_W-1:0];

  for (genvar i = 0; i < NCPU; i++) begin : g_bit
    localparam logic RST_VAL = (i < BOOT_CPUS);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) map_q[i] <= RST_VAL;
      else if (req_ok_o && bit_idx == IDX_W'(i)) map_q[i] <= req_plug_i;
    end
  end

  assign rd_byte_o = map_q[{rd_idx_i, 3'b000} +: 8];

  a_r3_plug_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok_o && req_plug_i |=> map_q[$past(bit_idx)]);
  a_r3_unplug_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ok_o && !req_plug_i |=> !map_q[$past(bit_idx)]);
  a_r5_oob_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_id_i[ID_W-1] |=> $stable(map_q));
  a_r6_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(map_q));
endmodule

// File: rtl/cpuhp_gpe_block.sv
module cpuhp_gpe_block
  import cpuhp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  gpe_sel_e   sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       cpu_evt_i,
  input  logic       pci_evt_i,
  input  logic       pm_evt_i,
  output logic [7:0] rd_data_o,
  output logic       sci_o
);
  logic [7:0] sts0_q, sts1_q, en0_q, en1_q;
  logic [7:0] sts0_set, sts0_clr;

  always_comb begin
    sts0_set = '0;
    sts0_set[CPU_HP_BIT] = cpu_evt_i;
    sts0_set[PCI_HP_BIT] = pci_evt_i;
    sts0_clr = (wr_en_i && sel_i == GPE_STS0) ? wr_data_i : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts0_q <= '0;
      sts1_q <= '0;
      en0_q  <= '0;
      en1_q  <= '0;
    end else begin
      // set has priority over a concurrent clear
      sts0_q <= (sts0_q & ~sts0_clr) | sts0_set;
      if (wr_en_i && sel_i == GPE_STS1) sts1_q <= sts1_q & ~wr_data_i;
      if (wr_en_i && sel_i == GPE_EN0)  en0_q  <= wr_data_i;
      if (wr_en_i && sel_i == GPE_EN1)  en1_q  <= wr_data_i;
    end
  end

  always_comb begin
    unique case (sel_i)
      GPE_STS0: rd_data_o = sts0_q;
      GPE_STS1: rd_data_o = sts1_q;
      GPE_EN0:  rd_data_o = en0_q;
      default:  rd_data_o = en1_q;
    endcase
  end

  assign sci_o = |(sts0_q & en0_q & SCI_SRC_MASK) || pm_evt_i;

  a_r4_cpu_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_evt_i |=> sts0_q[CPU_HP_BIT]);
  a_r9_pci_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_evt_i |=> sts0_q[PCI_HP_BIT]);
  a_r7_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && sel_i == GPE_STS0 && wr_data_i[CPU_HP_BIT] && !cpu_evt_i
    |=> !sts0_q[CPU_HP_BIT]);
  a_r8_sci_enabled_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts0_q[CPU_HP_BIT] && en0_q[CPU_HP_BIT] |-> sci_o);
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_evt_i && wr_en_i && sel_i == GPE_STS0 |=> sts0_q[CPU_HP_BIT]);
endmodule

// File: rtl/cpu_hotplug_gpe.sv
module cpu_hotplug_gpe
  import cpuhp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MAP_BASE = 16'hAF00, // aligned to MAP_BYTES
  parameter logic [ADDR_W-1:0] GPE_BASE = 16'hAFE0, // aligned to 4
  parameter int MAP_BYTES = 32,
  parameter int BOOT_CPUS = 4,
  localparam int NCPU  = MAP_BYTES * 8,
  localparam int ID_W  = $clog2(NCPU) + 1,
  localparam int OFF_W = $clog2(MAP_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o,
  output logic              io_ack_o,
  input  logic              req_valid_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic              req_plug_i,
  input  logic              pci_evt_i,
  input  logic              pm_evt_i,
  output logic              sci_o
);
  logic map_hit, gpe_hit, req_ok;
  logic [7:0] map_byte, gpe_byte;
  logic [7:0] rdata_q;
  logic ack_q;

  assign map_hit = io_addr_i[ADDR_W-1:OFF_W] == MAP_BASE[ADDR_W-1:OFF_W];
  assign gpe_hit = io_addr_i[ADDR_W-1:2] == GPE_BASE[ADDR_W-1:2];

  cpuhp_present_map #(.MAP_BYTES(MAP_BYTES), .BOOT_CPUS(BOOT_CPUS)) u_map (
    .clk_i, .rst_ni,
    .req_valid_i,
    .req_id_i,
    .req_plug_i,
    .rd_idx_i  (io_addr_i[OFF_W-1:0]),
    .rd_byte_o (map_byte),
    .req_ok_o  (req_ok)
  );

  cpuhp_gpe_block u_gpe (
    .clk_i, .rst_ni,
    .wr_en_i   (io_wr_i && gpe_hit),
    .sel_i     (gpe_sel_e'(io_addr_i[1:0])),
    .wr_data_i (io_wdata_i),
    .cpu_evt_i (req_ok),
    .pci_evt_i,
    .pm_evt_i,
    .rd_data_o (gpe_byte),
    .sci_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= io_rd_i && (map_hit || gpe_hit);
      rdata_q <= !io_rd_i ? 8'h00 : map_hit ? map_byte : gpe_hit ? gpe_byte : 8'h00;
    end
  end

  assign io_ack_o   = ack_q;
  assign io_rdata_o = rdata_q;

  a_r11_no_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i && !map_hit && !gpe_hit |=> !io_ack_o && io_rdata_o == 8'h00);
  a_r2_map_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_i && map_hit |=> io_ack_o);
endmodule

// File: tb/sim_cpu_hotplug_gpe.sv
module sim_cpu_hotplug_gpe;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic io_rd = 0, io_wr = 0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic io_ack;
  logic req_valid = 0, req_plug = 0, pci_evt = 0, pm_evt = 0;
  logic [8:0] req_id = '0;
  logic sci;

  int errors = 0, checks = 0, cycles = 0;
  logic [255:0] m_map;
  logic [7:0] m_sts0, m_sts1, m_en0, m_en1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_hotplug_gpe u0 (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_rd_i(io_rd), .io_wr_i(io_wr),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .io_ack_o(io_ack),
    .req_valid_i(req_valid), .req_id_i(req_id), .req_plug_i(req_plug),
    .pci_evt_i(pci_evt), .pm_evt_i(pm_evt), .sci_o(sci)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_sci();
    return ((m_sts0 & m_en0 & 8'h06) != 0) || pm_evt;
  endfunction

  function automatic logic [7:0] exp_byte(logic [15:0] a);
    if (a[15:5] == 11'h578) return m_map[{a[4:0], 3'b000} +: 8];
    case (a)
      16'hAFE0: return m_sts0;
      16'hAFE1: return m_sts1;
      16'hAFE2: return m_en0;
      16'hAFE3: return m_en1;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic exp_ack(logic [15:0] a);
    return a[15:5] == 11'h578 || a[15:2] == 14'h2BF8;
  endfunction

  task automatic rd(logic [15:0] a, string req);
    @(negedge clk); io_addr = a; io_rd = 1;
    @(negedge clk); io_rd = 0;
    check(req, {31'd0, io_ack}, {31'd0, exp_ack(a)});
    check(req, {24'd0, io_rdata}, {24'd0, exp_byte(a)});
  endtask

  // one cycle with optional request, host write and PCI pulse; model updated after edge
  task automatic cyc(logic rv, logic [8:0] id, logic pl, logic wv, logic [15:0] a,
                     logic [7:0] d, logic pe);
    @(negedge clk);
    req_valid = rv; req_id = id; req_plug = pl; io_wr = wv; io_addr = a; io_wdata = d;
    pci_evt = pe;
    @(negedge clk);
    req_valid = 0; io_wr = 0; pci_evt = 0;
    if (wv) case (a)
      16'hAFE0: m_sts0 &= ~d;
      16'hAFE1: m_sts1 &= ~d;
      16'hAFE2: m_en0 = d;
      16'hAFE3: m_en1 = d;
      default: ;
    endcase
    if (rv && id < 256) begin m_map[id[7:0]] = pl; m_sts0[2] = 1'b1; end
    if (pe) m_sts0[1] = 1'b1;
    check("R8", {31'd0, sci}, {31'd0, exp_sci()});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_map = 256'hF; m_sts0 = 0; m_sts1 = 0; m_en0 = 0; m_en1 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1", {31'd0, sci}, 32'd0);
    for (int k = 0; k < 32; k++) rd(16'hAF00 + 16'(k), "R1 R2");
    for (int k = 0; k < 4; k++) rd(16'hAFE0 + 16'(k), "R1 R7");
    // R3 R4 plug and unplug, edge IDs
    cyc(1, 9'd255, 1, 0, 0, 0, 0); rd(16'hAF1F, "R3 plug id 255");
    rd(16'hAFE0, "R4 status bit 2");
    cyc(1, 9'd0, 0, 0, 0, 0, 0);   rd(16'hAF00, "R3 unplug id 0");
    // R8 enable routing
    cyc(0, 0, 0, 1, 16'hAFE2, 8'h04, 0); check("R8 enabled cpu", {31'd0, sci}, 32'd1);
    // R7 W1C
    cyc(0, 0, 0, 1, 16'hAFE0, 8'h04, 0); rd(16'hAFE0, "R7 w1c");
    // R5 out of range
    cyc(1, 9'd256, 1, 0, 0, 0, 0); rd(16'hAFE0, "R5 no status"); rd(16'hAF00, "R5 no map");
    cyc(1, 9'd511, 0, 0, 0, 0, 0); rd(16'hAF1F, "R5 id 511");
    // R6 map writes ignored
    cyc(0, 0, 0, 1, 16'hAF00, 8'hFF, 0); rd(16'hAF00, "R6 map write");
    cyc(0, 0, 0, 1, 16'hAF1F, 8'h00, 0); rd(16'hAF1F, "R6 map write");
    // R10 set wins
    cyc(1, 9'd77, 1, 1, 16'hAFE0, 8'hFF, 0); rd(16'hAFE0, "R10 set wins");
    check("R10 sci", {31'd0, sci}, {31'd0, exp_sci()});
    // R9 PCI event
    cyc(0, 0, 0, 1, 16'hAFE2, 8'h02, 0);
    cyc(0, 0, 0, 0, 0, 0, 1); rd(16'hAFE0, "R9 pci status");
    check("R9 sci", {31'd0, sci}, 32'd1);
    // R8 pm path
    cyc(0, 0, 0, 1, 16'hAFE2, 8'h00, 0);
    @(negedge clk); pm_evt = 1; #1 check("R8 pm", {31'd0, sci}, 32'd1);
    @(negedge clk); pm_evt = 0; #1 check("R8 pm off", {31'd0, sci}, 32'd0);
    // R11 outside windows
    rd(16'hAF20, "R11"); rd(16'hAEFF, "R11"); rd(16'hAFE4, "R11"); rd(16'h0000, "R11");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] wa;
      logic [1:0] sel;
      sel = 2'($urandom_range(0, 3));
      wa = ($urandom_range(0, 3) == 0) ? 16'hAF00 + 16'($urandom_range(0, 31)) : 16'hAFE0 + 16'(sel);
      cyc(1'($urandom_range(0, 1)), 9'($urandom_range(0, 300)), 1'($urandom_range(0, 1)),
          ($urandom_range(0, 3) == 0), wa, 8'($urandom), ($urandom_range(0, 7) == 0));
      if (n % 20 == 0) rd(16'hAF00 + 16'($urandom_range(0, 31)), "R2 R3 random");
    end
    for (int k = 0; k < 32; k++) rd(16'hAF00 + 16'(k), "R2 R3 final map");
    for (int k = 0; k < 4; k++) rd(16'hAFE0 + 16'(k), "R7 final gpe");
    finish_run();
  end
endmodule